// File: doc/BRIEF.md
# Function-unit register dependency matrix

This block tracks, for every function-unit row, which architectural registers an issued operation still has to read and which register it will write. Several rows share one physical ALU. Each row acts as a reservation station: it keeps its own latched copies of its source operands until the ALU finishes with it. An issue port loads a row. The row then fetches its operands from a register file that is split into four banks by register number modulo four. A write-back port retires the row and stores its result.

Each source slot that still needs its value requests the bank that holds its register. A fixed-priority arbiter in each bank grants one slot per cycle, and the bank's read data is latched into the winning row. A row may write only the bank whose number equals its own index modulo four. The write path therefore comes straight from the row with no multiplexer. A read waits while a row issued earlier, and still live, is due to write that register.

Top module: `fu_regdep_matrix`

## Requirements
- R1: After reset no row is busy or ready, no bank shows a read grant, and every register holds zero.
- R2: An issue is taken only when the addressed row is idle and either the operation has no destination or the destination's low two bits equal the row index's low two bits. A taken issue makes the row busy in the next cycle and marks each enabled source as needing a read. Any other issue is ignored and leaves the row's state unchanged.
- R3: A row reports ready while it is busy and none of its source slots still needs a read. An operation with no sources is ready in the cycle after issue.
- R4: A pending source read requests the bank given by the low two bits of its register number. Each bank grants at most one request per cycle. Within a bank the lowest row index wins, and slot A beats slot B of the same row. A losing request retries in the next cycle.
- R5: A granted slot latches the bank's current value of its register at the clock edge that ends the grant cycle, and its need-read mark clears at that edge. A row's latched pair appears on the ALU operand outputs when the ALU select input names that row.
- R6: A source read stays blocked while some row that was already busy when the reader issued is still busy and is due to write that register. A writer issued later than the reader does not block it, and neither does the reader's own destination.
- R7: Write-back is taken only for a ready row. It frees the row in the next cycle and, if the row has a destination, writes the result through the bank numbered by the row index's low two bits. Write-back to a row that is idle or still waiting on a read is ignored.
- R8: A read grant and a write-back in the same bank and the same cycle both take effect, and the reader gets the value from before the write. A read that a write-back unblocks is granted in the next cycle and gets the written value.
- R9: Rows that read the same register each keep their own operand copy, independent of later register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | Issue request |
| iss_row | input | 4 | Row to load |
| iss_src_a_en | input | 1 | Source A present |
| iss_src_a | input | 5 | Source A register |
| iss_src_b_en | input | 1 | Source B present |
| iss_src_b | input | 5 | Source B register |
| iss_dst_en | input | 1 | Destination present |
| iss_dst | input | 5 | Destination register |
| wb_valid | input | 1 | Write-back request |
| wb_row | input | 4 | Row being retired |
| wb_data | input | 32 | Result value |
| alu_sel | input | 4 | Row whose operands the ALU reads |
| alu_opnd_a | output | 32 | Latched source A of the selected row |
| alu_opnd_b | output | 32 | Latched source B of the selected row |
| row_busy | output | 16 | Row holds an operation |
| row_ready | output | 16 | Row has all its operands |
| rd_gnt_valid | output | 4 | Bank grants a read this cycle |
| rd_gnt_row | output | 4x4 | Row that holds each bank's grant |

## Verification
Two functions can land in the same cycle. One is a bank's read grant. The other is a write-back through that same bank, either to a different register or releasing a blocked reader. The bench lines these up by issuing a reader whose grant becomes visible and then driving a write-back of an older row into the same bank before the next edge. It then compares the reader's latched operand with the value from before the write, and a later readback with the value written. A second case parks two readers on a pending write and releases them with one write-back. The grant order seen on the bank outputs and the operand values, which must be the new ones, are compared with what the requirements predict.

// File: rtl/fum_pkg.sv
package fum_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_slot_e;
  localparam int unsigned SRC_PER_ROW = 2;
endpackage

// File: rtl/fum_bank_arb.sv
module fum_bank_arb #(
  parameter int N_REQ = 32,
  parameter int IDX_W = 5
) (
  input  logic [N_REQ-1:0] req,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    gnt_valid = |req;
    gnt_idx   = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (req[k]) gnt_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/fum_reg_bank.sv
module fum_reg_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem_q <= '0;
    else if (we) mem_q <= mem_d;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/fum_row.sv
module fum_row #(
  parameter int NUM_ROWS = 16,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           iss_hit,
  input  logic                           iss_src_a_en,
  input  logic [REG_W-1:0]               iss_src_a,
  input  logic                           iss_src_b_en,
  input  logic [REG_W-1:0]               iss_src_b,
  input  logic                           iss_dst_en,
  input  logic [REG_W-1:0]               iss_dst,
  input  logic [NUM_ROWS-1:0]            iss_older,
  input  logic                           wb_hit,
  input  logic [NUM_ROWS-1:0]            free_vec,
  input  logic [NUM_ROWS-1:0]            pend_wr,
  input  logic [NUM_ROWS-1:0][REG_W-1:0] pend_dst,
  input  logic                           gnt_a,
  input  logic                           gnt_b,
  input  logic [DATA_W-1:0]              rdat_a,
  input  logic [DATA_W-1:0]              rdat_b,
  output logic                           busy,
  output logic                           ready,
  output logic                           req_a,
  output logic                           req_b,
  output logic [REG_W-1:0]               src_a,
  output logic [REG_W-1:0]               src_b,
  output logic                           need_wr,
  output logic [REG_W-1:0]               dst,
  output logic [DATA_W-1:0]              opnd_a,
  output logic [DATA_W-1:0]              opnd_b
);
  logic                busy_q, busy_d;
  logic                need_a_q, need_a_d, need_b_q, need_b_d;
  logic                need_wr_q, need_wr_d;
  logic [NUM_ROWS-1:0] older_q, older_d;
  logic [REG_W-1:0]    src_a_q, src_b_q, dst_q;
  logic [DATA_W-1:0]   opnd_a_q, opnd_b_q;
  logic                blk_a, blk_b;

  // a read waits on any still-pending writer that was live at this row's issue
  always_comb begin
    blk_a = 1'b0;
    blk_b = 1'b0;
    for (int j = 0; j < NUM_ROWS; j++) begin
      if (older_q[j] && pend_wr[j] && (pend_dst[j] == src_a_q)) blk_a = 1'b1;
      if (older_q[j] && pend_wr[j] && (pend_dst[j] == src_b_q)) blk_b = 1'b1;
    end
  end

  always_comb begin
    busy_d    = busy_q;
    need_a_d  = need_a_q;
    need_b_d  = need_b_q;
    need_wr_d = need_wr_q;
    older_d   = older_q & ~free_vec;
    if (gnt_a) need_a_d = 1'b0;
    if (gnt_b) need_b_d = 1'b0;
    if (wb_hit) begin
      busy_d    = 1'b0;
      need_wr_d = 1'b0;
      older_d   = '0;
    end
    if (iss_hit) begin
      busy_d    = 1'b1;
      need_a_d  = iss_src_a_en;
      need_b_d  = iss_src_b_en;
      need_wr_d = iss_dst_en;
      older_d   = iss_older;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      need_a_q  <= 1'b0;
      need_b_q  <= 1'b0;
      need_wr_q <= 1'b0;
      older_q   <= '0;
    end else begin
      busy_q    <= busy_d;
      need_a_q  <= need_a_d;
      need_b_q  <= need_b_d;
      need_wr_q <= need_wr_d;
      older_q   <= older_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_a_q <= '0;
      src_b_q <= '0;
      dst_q   <= '0;
    end else if (iss_hit) begin
      src_a_q <= iss_src_a;
      src_b_q <= iss_src_b;
      dst_q   <= iss_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     opnd_a_q <= '0;
    else if (gnt_a) opnd_a_q <= rdat_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     opnd_b_q <= '0;
    else if (gnt_b) opnd_b_q <= rdat_b;
  end

  assign busy    = busy_q;
  assign ready   = busy_q && !need_a_q && !need_b_q;
  assign req_a   = need_a_q && !blk_a;
  assign req_b   = need_b_q && !blk_b;
  assign src_a   = src_a_q;
  assign src_b   = src_b_q;
  assign need_wr = need_wr_q;
  assign dst     = dst_q;
  assign opnd_a  = opnd_a_q;
  assign opnd_b  = opnd_b_q;
endmodule

// File: rtl/fu_regdep_matrix.sv
module fu_regdep_matrix
  import fum_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            iss_valid,
  input  logic [ROW_W-1:0]                iss_row,
  input  logic                            iss_src_a_en,
  input  logic [REG_W-1:0]                iss_src_a,
  input  logic                            iss_src_b_en,
  input  logic [REG_W-1:0]                iss_src_b,
  input  logic                            iss_dst_en,
  input  logic [REG_W-1:0]                iss_dst,
  input  logic                            wb_valid,
  input  logic [ROW_W-1:0]                wb_row,
  input  logic [DATA_W-1:0]               wb_data,
  input  logic [ROW_W-1:0]                alu_sel,
  output logic [DATA_W-1:0]               alu_opnd_a,
  output logic [DATA_W-1:0]               alu_opnd_b,
  output logic [NUM_ROWS-1:0]             row_busy,
  output logic [NUM_ROWS-1:0]             row_ready,
  output logic [NUM_BANKS-1:0]            rd_gnt_valid,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] rd_gnt_row
);
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int BANK_DEPTH = NUM_REGS / NUM_BANKS;
  localparam int LADDR_W    = REG_W - BANK_W;
  localparam int NREQ       = NUM_ROWS * SRC_PER_ROW;
  localparam int RQ_W       = $clog2(NREQ);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_ROWS-1:0]              busy, ready, req_a, req_b, need_wr;
  logic [NUM_ROWS-1:0]              gnt_a, gnt_b, free_vec, iss_older;
  logic [NUM_ROWS-1:0][REG_W-1:0]   src_a, src_b, dst;
  logic [NUM_ROWS-1:0][DATA_W-1:0]  rdat_a, rdat_b, opnd_a, opnd_b;
  logic [NUM_BANKS-1:0][NREQ-1:0]   bank_req;
  logic [NUM_BANKS-1:0]             bank_gv, bank_we;
  logic [NUM_BANKS-1:0][RQ_W-1:0]   bank_gi;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [LADDR_W-1:0]               wr_laddr;
  logic                             iss_ok, wb_ok;

  assign iss_ok = iss_valid && !busy[iss_row] &&
                  (!iss_dst_en || (iss_dst[BANK_W-1:0] == iss_row[BANK_W-1:0]));
  assign wb_ok  = wb_valid && ready[wb_row];

  always_comb begin
    free_vec = '0;
    if (wb_ok) free_vec[wb_row] = 1'b1;
  end
  assign iss_older = busy & ~free_vec;
  assign wr_laddr  = dst[wb_row][REG_W-1:BANK_W];

  // request routing: entry 2*i is slot A of row i, 2*i+1 is slot B
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < NUM_ROWS; i++) begin
        bank_req[b][SRC_PER_ROW*i]     = req_a[i] && (src_a[i][BANK_W-1:0] == BANK_W'(b));
        bank_req[b][SRC_PER_ROW*i + 1] = req_b[i] && (src_b[i][BANK_W-1:0] == BANK_W'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ROW_W-1:0]   sel_row;
    src_slot_e          sel_slot;
    logic [REG_W-1:0]   sel_reg;
    logic [LADDR_W-1:0] rd_laddr;

    fum_bank_arb #(.N_REQ(NREQ), .IDX_W(RQ_W)) u_arb (
      .req       (bank_req[b]),
      .gnt_valid (bank_gv[b]),
      .gnt_idx   (bank_gi[b])
    );

    assign sel_row  = bank_gi[b][RQ_W-1:1];
    assign sel_slot = src_slot_e'(bank_gi[b][0]);
    assign sel_reg  = (sel_slot == SRC_B) ? src_b[sel_row] : src_a[sel_row];
    assign rd_laddr = sel_reg[REG_W-1:BANK_W];

    // write port is fixed to rows whose index residue equals this bank
    assign bank_we[b] = wb_ok && need_wr[wb_row] &&
                        (wb_row[BANK_W-1:0] == BANK_W'(b));

    fum_reg_bank #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W), .ADDR_W(LADDR_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (bank_we[b]),
      .waddr (wr_laddr),
      .wdata (wb_data),
      .raddr (rd_laddr),
      .rdata (bank_rdata[b])
    );

    assign rd_gnt_valid[b] = bank_gv[b];
    assign rd_gnt_row[b]   = sel_row;
  end

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [BANK_W-1:0] bk_a, bk_b;
    assign bk_a      = src_a[i][BANK_W-1:0];
    assign bk_b      = src_b[i][BANK_W-1:0];
    assign gnt_a[i]  = bank_gv[bk_a] && (bank_gi[bk_a] == RQ_W'(SRC_PER_ROW*i));
    assign gnt_b[i]  = bank_gv[bk_b] && (bank_gi[bk_b] == RQ_W'(SRC_PER_ROW*i + 1));
    assign rdat_a[i] = bank_rdata[bk_a];
    assign rdat_b[i] = bank_rdata[bk_b];

    fum_row #(.NUM_ROWS(NUM_ROWS), .REG_W(REG_W), .DATA_W(DATA_W)) u_row (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .iss_hit      (iss_ok && (iss_row == ROW_W'(i))),
      .iss_src_a_en (iss_src_a_en),
      .iss_src_a    (iss_src_a),
      .iss_src_b_en (iss_src_b_en),
      .iss_src_b    (iss_src_b),
      .iss_dst_en   (iss_dst_en),
      .iss_dst      (iss_dst),
      .iss_older    (iss_older),
      .wb_hit       (free_vec[i]),
      .free_vec     (free_vec),
      .pend_wr      (need_wr),
      .pend_dst     (dst),
      .gnt_a        (gnt_a[i]),
      .gnt_b        (gnt_b[i]),
      .rdat_a       (rdat_a[i]),
      .rdat_b       (rdat_b[i]),
      .busy         (busy[i]),
      .ready        (ready[i]),
      .req_a        (req_a[i]),
      .req_b        (req_b[i]),
      .src_a        (src_a[i]),
      .src_b        (src_b[i]),
      .need_wr      (need_wr[i]),
      .dst          (dst[i]),
      .opnd_a       (opnd_a[i]),
      .opnd_b       (opnd_b[i])
    );
  end

  assign row_busy   = busy;
  assign row_ready  = ready;
  assign alu_opnd_a = opnd_a[alu_sel];
  assign alu_opnd_b = opnd_b[alu_sel];
endmodule

// File: rtl/fu_regdep_matrix_chk.sv
module fu_regdep_matrix_chk #(
  parameter int NUM_ROWS  = 16,
  parameter int NUM_REGS  = 32,
  parameter int NUM_BANKS = 4,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            iss_valid,
  input logic [ROW_W-1:0]                iss_row,
  input logic                            iss_dst_en,
  input logic [REG_W-1:0]                iss_dst,
  input logic                            wb_valid,
  input logic [ROW_W-1:0]                wb_row,
  input logic [NUM_ROWS-1:0]             row_busy,
  input logic [NUM_ROWS-1:0]             row_ready,
  input logic [NUM_BANKS-1:0]            rd_gnt_valid,
  input logic [NUM_BANKS-1:0][ROW_W-1:0] rd_gnt_row
);
  logic dst_fits;
  assign dst_fits = !iss_dst_en || (iss_dst[BANK_W-1:0] == iss_row[BANK_W-1:0]);

  assert_ready_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ready & ~row_busy) == '0);

  assert_issue_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !row_busy[iss_row] && dst_fits |=> row_busy[$past(iss_row)]);

  assert_issue_bad_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !row_busy[iss_row] && !dst_fits |=> !row_busy[$past(iss_row)]);

  assert_wb_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && row_ready[wb_row] |=> !row_busy[$past(wb_row)]);

  assert_wb_early_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && row_busy[wb_row] && !row_ready[wb_row] |=> row_busy[$past(wb_row)]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
    assert_grant_to_waiting_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt_valid[b] |-> row_busy[rd_gnt_row[b]] && !row_ready[rd_gnt_row[b]]);
  end
endmodule

bind fu_regdep_matrix fu_regdep_matrix_chk #(
  .NUM_ROWS (NUM_ROWS),
  .NUM_REGS (NUM_REGS),
  .NUM_BANKS(NUM_BANKS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .iss_valid    (iss_valid),
  .iss_row      (iss_row),
  .iss_dst_en   (iss_dst_en),
  .iss_dst      (iss_dst),
  .wb_valid     (wb_valid),
  .wb_row       (wb_row),
  .row_busy     (row_busy),
  .row_ready    (row_ready),
  .rd_gnt_valid (rd_gnt_valid),
  .rd_gnt_row   (rd_gnt_row)
);

// File: tb/fu_regdep_matrix_tb_top.sv
`timescale 1ns/100ps
module fu_regdep_matrix_tb_top;
  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 iss_valid, iss_src_a_en, iss_src_b_en, iss_dst_en;
  logic [3:0]           iss_row;
  logic [4:0]           iss_src_a, iss_src_b, iss_dst;
  logic                 wb_valid;
  logic [3:0]           wb_row;
  logic [31:0]          wb_data;
  logic [3:0]           alu_sel;
  logic [31:0]          alu_opnd_a, alu_opnd_b;
  logic [15:0]          row_busy, row_ready;
  logic [3:0]           rd_gnt_valid;
  logic [3:0][3:0]      rd_gnt_row;

  int checks = 0;
  int errors = 0;
  logic [31:0] regs [32];

  typedef struct {
    int          row;
    logic [31:0] a;
    logic [31:0] b;
    bit          chk_b;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  fu_regdep_matrix dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_row(iss_row),
    .iss_src_a_en(iss_src_a_en), .iss_src_a(iss_src_a),
    .iss_src_b_en(iss_src_b_en), .iss_src_b(iss_src_b),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
    .wb_valid(wb_valid), .wb_row(wb_row), .wb_data(wb_data),
    .alu_sel(alu_sel), .alu_opnd_a(alu_opnd_a), .alu_opnd_b(alu_opnd_b),
    .row_busy(row_busy), .row_ready(row_ready),
    .rd_gnt_valid(rd_gnt_valid), .rd_gnt_row(rd_gnt_row)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int row, bit ae, int a, bit be, int b, bit de, int d);
    iss_valid = 1'b1; iss_row = 4'(row);
    iss_src_a_en = ae; iss_src_a = 5'(a);
    iss_src_b_en = be; iss_src_b = 5'(b);
    iss_dst_en = de;   iss_dst = 5'(d);
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic wback(int row, logic [31:0] d);
    wb_valid = 1'b1; wb_row = 4'(row); wb_data = d;
    tick();
    wb_valid = 1'b0;
  endtask

  task automatic expect_ops(int row, logic [31:0] a, logic [31:0] b, bit cb);
    exp_t e;
    e.row = row; e.a = a; e.b = b; e.chk_b = cb;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) tick();
  endtask

  // monitor: once the head row is ready, select it and compare operands (R5, R9)
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1 && exp_q.size() > 0) begin
      if (row_ready[exp_q[0].row]) begin
        alu_sel = 4'(exp_q[0].row);
        #1;
        chk($sformatf("R5 row %0d operand A", exp_q[0].row), alu_opnd_a, exp_q[0].a);
        if (exp_q[0].chk_b)
          chk($sformatf("R9 row %0d operand B", exp_q[0].row), alu_opnd_b, exp_q[0].b);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_row = '0; iss_src_a_en = 1'b0; iss_src_a = '0;
    iss_src_b_en = 1'b0; iss_src_b = '0; iss_dst_en = 1'b0; iss_dst = '0;
    wb_valid = 1'b0; wb_row = '0; wb_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 idle after reset
    chk("R1 busy", 32'(row_busy), 32'h0);
    chk("R1 ready", 32'(row_ready), 32'h0);
    chk("R1 grants", 32'(rd_gnt_valid), 32'h0);

    // load every register through its own residue row (R3, R7)
    for (int r = 0; r < 32; r++) begin
      issue(r % 4, 0, 0, 0, 0, 1, r);
      chk("R3 no-source row ready", 32'(row_ready[r % 4]), 32'h1);
      regs[r] = 32'hC0DE_0000 | (32'(r) * 32'h101);
      wback(r % 4, regs[r]);
    end

    // R4: two sources in bank 3 served one per cycle, slot A first
    issue(5, 1, 3, 1, 7, 0, 0);
    chk("R4 bank3 grant valid", 32'(rd_gnt_valid[3]), 32'h1);
    chk("R4 bank3 grant row", 32'(rd_gnt_row[3]), 32'd5);
    chk("R3 not ready while reading", 32'(row_ready[5]), 32'h0);
    expect_ops(5, regs[3], regs[7], 1);
    tick();
    chk("R4 second slot retries", 32'(rd_gnt_valid[3]), 32'h1);
    drain();
    wback(5, 32'h0);
    chk("R7 row freed", 32'(row_busy[5]), 32'h0);

    // R4: two banks serve one row in the same cycle
    issue(6, 1, 1, 1, 2, 0, 0);
    chk("R4 bank1 and bank2 together", 32'(rd_gnt_valid[1] & rd_gnt_valid[2]), 32'h1);
    expect_ops(6, regs[1], regs[2], 1);
    tick();
    chk("R3 ready after one grant cycle", 32'(row_ready[6]), 32'h1);
    drain();
    wback(6, 32'h0);

    // R6/R4/R8: two readers parked on a pending write, released together
    issue(2, 0, 0, 0, 0, 1, 2);
    issue(9, 1, 2, 0, 0, 0, 0);
    issue(6, 1, 2, 0, 0, 0, 0);
    chk("R6 readers blocked", 32'(rd_gnt_valid[2]), 32'h0);
    regs[2] = 32'h1234_5678;
    expect_ops(9, regs[2], 0, 0);
    expect_ops(6, regs[2], 0, 0);
    wback(2, regs[2]);
    chk("R8 unblocked next cycle", 32'(rd_gnt_valid[2]), 32'h1);
    chk("R4 lowest row first", 32'(rd_gnt_row[2]), 32'd6);
    tick();
    chk("R4 loser served next", 32'(rd_gnt_row[2]), 32'd9);
    drain();
    wback(6, 32'h0);
    wback(9, 32'h0);

    // R6: a younger writer does not block an older reader
    issue(1, 0, 0, 0, 0, 1, 9);
    issue(14, 1, 9, 0, 0, 0, 0);
    chk("R6 older writer blocks", 32'(rd_gnt_valid[1]), 32'h0);
    issue(5, 0, 0, 0, 0, 1, 9);
    chk("R6 still blocked", 32'(rd_gnt_valid[1]), 32'h0);
    regs[9] = 32'hAAAA_0009;
    expect_ops(14, regs[9], 0, 0);
    wback(1, regs[9]);
    chk("R6 younger writer ignored", 32'(rd_gnt_valid[1]), 32'h1);
    chk("R6 reader row", 32'(rd_gnt_row[1]), 32'd14);
    drain();
    wback(14, 32'h0);
    // R6: own destination does not block own read
    issue(13, 1, 13, 0, 0, 1, 13);
    chk("R6 self not blocking", 32'(rd_gnt_row[1]), 32'd13);
    expect_ops(13, regs[13], 0, 0);
    drain();
    regs[13] = 32'hBBBB_0013;
    wback(13, regs[13]);
    regs[9] = 32'hCCCC_0009;
    wback(5, regs[9]);

    // R2: wrong destination residue and issue into a busy row are ignored
    issue(3, 0, 0, 0, 0, 1, 4);
    chk("R2 bad residue ignored", 32'(row_busy[3]), 32'h0);
    issue(0, 0, 0, 0, 0, 1, 0);
    issue(0, 1, 1, 0, 0, 0, 0);
    chk("R2 busy row keeps ready", 32'(row_ready[0]), 32'h1);
    chk("R2 busy row no request", 32'(rd_gnt_valid[1]), 32'h0);
    regs[0] = 32'hDDDD_0000;
    wback(0, regs[0]);
    chk("R7 row 0 freed", 32'(row_busy[0]), 32'h0);

    // R7: write-back to a row still waiting on a read is ignored
    issue(3, 0, 0, 0, 0, 1, 3);
    issue(11, 1, 3, 0, 0, 1, 7);
    chk("R6 blocked on r3", 32'(rd_gnt_valid[3]), 32'h0);
    wback(11, 32'hDEAD_BEEF);
    chk("R7 early write-back ignored", 32'(row_busy[11]), 32'h1);
    regs[3] = 32'hEEEE_0003;
    expect_ops(11, regs[3], 0, 0);
    wback(3, regs[3]);
    chk("R8 release grant row", 32'(rd_gnt_row[3]), 32'd11);
    drain();
    regs[7] = 32'hFFFF_0007;
    wback(11, regs[7]);

    // R8: read grant and write-back share bank 0 in one cycle
    issue(0, 0, 0, 0, 0, 1, 8);
    issue(4, 1, 12, 0, 0, 0, 0);
    chk("R8 grant in shared cycle", 32'(rd_gnt_valid[0]), 32'h1);
    chk("R8 grant row", 32'(rd_gnt_row[0]), 32'd4);
    expect_ops(4, regs[12], 0, 0);
    regs[8] = 32'h0808_0808;
    wback(0, regs[8]);
    drain();
    wback(4, 32'h0);

    // readback of the registers written above (R7, R9)
    issue(15, 1, 8, 1, 7, 0, 0);
    expect_ops(15, regs[8], regs[7], 1);
    issue(10, 1, 3, 1, 9, 0, 0);
    expect_ops(10, regs[3], regs[9], 1);
    issue(12, 1, 0, 1, 13, 0, 0);
    expect_ops(12, regs[0], regs[13], 1);
    drain();
    wback(15, 32'h0);
    wback(10, 32'h0);
    wback(12, 32'h0);
    chk("R7 all rows idle", 32'(row_busy), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule